// File: doc/BRIEF.md
# Hall-Sensor Block Commutation Controller

This block drives the six phase lines of a three-phase motor bridge from three rotor-position sensor inputs. The raw sensor levels are synchronized and debounced. Each accepted change of the 3-bit sensor state selects a new six-line output pattern from one of two programmable tables, one for forward rotation and one for reverse. In this mode the six lines are owned only by the commutation logic and do not carry the chip's ordinary capture/compare channel outputs. Each line can be held low, held high, driven by an external PWM source such as a 10-bit compare unit, or driven by that PWM inverted.

Every accepted sensor transition also captures the value of a free-running compare timer, so that the time between commutation steps can be used to measure speed. A second operating mode, multi-channel PWM, leaves pattern loading to the compare timer's period event: sensor transitions are still captured, but the lines change only when the period event arrives.

Top module: `hall_commutator`

## Requirements
- R1: Sensor inputs pass through two synchronizer flops and are accepted only after two consecutive equal synchronized samples that differ from the current state; a raw change held steady becomes the accepted state at the fourth rising clock edge after it appears, and a change lasting one clock is never accepted.
- R2: In sensor mode (`mc_mode_i`=0), an accepted transition loads the pattern for the new state from `tbl_fwd_i` when `dir_rev_i`=0 or from `tbl_rev_i` when `dir_rev_i`=1; the 2-bit code of line L for state S sits at bits [S*12 + 2*L +: 2] of the table.
- R3: Line codes: 00 drives the line low, 01 drives it high, 10 drives it with `pwm_i`, 11 drives it with the inverse of `pwm_i`; `pwm_i` reaches the lines without a register.
- R4: Every accepted sensor transition, in either mode, stores `timer_i` into `cap_val_o` at the same edge the state is accepted and raises `cap_vld_o` for exactly one cycle; `cap_val_o` holds its value otherwise.
- R5: In multi-channel mode (`mc_mode_i`=1), the pattern loads only at a clock edge where `period_evt_i` is high, using the currently accepted state and the direction table selected at that moment; sensor transitions do not change the lines.
- R6: Sensor states 000 and 111 are invalid: loading one drives all six lines low regardless of the table and sets `fault_o`, which stays high until a valid state is loaded.
- R7: In sensor mode, a change of `dir_rev_i` or a pulse on `period_evt_i` leaves the lines unchanged until the next accepted transition.
- R8: After reset, all lines are low, `fault_o` and `cap_vld_o` are low and `cap_val_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Raw rotor-position sensor levels |
| mc_mode_i | input | 1 | 0: sensor-edge loading, 1: period-event loading |
| dir_rev_i | input | 1 | 0: forward table, 1: reverse table |
| period_evt_i | input | 1 | Compare timer period event, one-cycle pulse |
| pwm_i | input | 1 | Modulating PWM signal |
| timer_i | input | 16 | Free-running compare timer value |
| tbl_fwd_i | input | 96 | Forward pattern table, 12 bits per state |
| tbl_rev_i | input | 96 | Reverse pattern table, 12 bits per state |
| phase_o | output | 6 | Motor phase lines |
| cap_val_o | output | 16 | Timer value captured on last accepted transition |
| cap_vld_o | output | 1 | One-cycle pulse marking a new capture |
| fault_o | output | 1 | Invalid sensor state loaded |

## Verification
On every cycle the assertions check that an invalid state keeps all lines low, that the accepted state never moves on two adjacent cycles, that a capture pulse lasts one cycle and that the captured value moves only with it, and that the pattern changes only on its mode's trigger: an accepted transition in sensor mode, a period event in multi-channel mode. Only the bench scenarios can show that the right table entry is chosen for each state and direction, that each line code gives the right level for both PWM phases, that the acceptance delay is exactly four edges, and that a one-cycle glitch is dropped.

// File: rtl/hall_comm_pkg.sv
package hall_comm_pkg;

   typedef enum logic [1:0] {
      LC_LOW   = 2'b00,
      LC_HIGH  = 2'b01,
      LC_PWM   = 2'b10,
      LC_PWM_N = 2'b11
   } line_code_e;

endpackage

// File: rtl/hall_sync_filter.sv
module hall_sync_filter #(
   parameter int SW          = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] raw_i,
   output logic [SW-1:0] cand_o,
   output logic [SW-1:0] state_o,
   output logic          accept_o
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("hall_sync_filter: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0][SW-1:0] chain_q;
   logic [SW-1:0]                  last_q;
   logic [SW-1:0]                  state_q;

   // synchronizer chain, oldest sample in the top element
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= '0;
         state_q <= '0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
         last_q  <= chain_q[SYNC_STAGES-1];
         if (accept_o) state_q <= chain_q[SYNC_STAGES-1];
      end
   end

   assign cand_o   = chain_q[SYNC_STAGES-1];
   assign accept_o = (cand_o == last_q) && (cand_o != state_q);
   assign state_o  = state_q;

   AST_STATE_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(state_q) |=> $stable(state_q)); // R1

endmodule

// File: rtl/hall_pattern_sel.sv
module hall_pattern_sel #(
   parameter int SW    = 3,
   parameter int NLINE = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_i,
   input  logic [SW-1:0]             state_i,
   input  logic                      dir_rev_i,
   input  logic [(2*NLINE<<SW)-1:0]  tbl_fwd_i,
   input  logic [(2*NLINE<<SW)-1:0]  tbl_rev_i,
   output logic [2*NLINE-1:0]        code_o,
   output logic                      fault_o
);

   localparam int CODE_W = 2 * NLINE;

   if (NLINE < 1) begin : g_bad_lines
      $error("hall_pattern_sel: NLINE must be at least 1");
   end
   if (SW < 2) begin : g_bad_width
      $error("hall_pattern_sel: SW must be at least 2");
   end

   logic [CODE_W-1:0] row;
   logic              bad_state;
   logic [CODE_W-1:0] code_q;
   logic              fault_q;

   always_comb begin
      if (dir_rev_i) row = tbl_rev_i[int'(state_i)*CODE_W +: CODE_W];
      else           row = tbl_fwd_i[int'(state_i)*CODE_W +: CODE_W];
      bad_state = (state_i == '0) || (state_i == '1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         fault_q <= 1'b0;
      end else if (load_i) begin
         code_q  <= bad_state ? '0 : row;
         fault_q <= bad_state;
      end
   end

   assign code_o  = code_q;
   assign fault_o = fault_q;

   AST_FAULT_CODES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> (code_q == '0)); // R6

endmodule

// File: rtl/hall_line_drive.sv
module hall_line_drive
   import hall_comm_pkg::*;
(
   input  logic [1:0] code_i,
   input  logic       pwm_i,
   output logic       line_o
);

   always_comb begin
      unique case (line_code_e'(code_i))
         LC_LOW:   line_o = 1'b0;
         LC_HIGH:  line_o = 1'b1;
         LC_PWM:   line_o = pwm_i;
         LC_PWM_N: line_o = ~pwm_i;
         default:  line_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator #(
   parameter int SW          = 3,
   parameter int NLINE       = 6,
   parameter int TW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SW-1:0]            hall_i,
   input  logic                     mc_mode_i,
   input  logic                     dir_rev_i,
   input  logic                     period_evt_i,
   input  logic                     pwm_i,
   input  logic [TW-1:0]            timer_i,
   input  logic [(2*NLINE<<SW)-1:0] tbl_fwd_i,
   input  logic [(2*NLINE<<SW)-1:0] tbl_rev_i,
   output logic [NLINE-1:0]         phase_o,
   output logic [TW-1:0]            cap_val_o,
   output logic                     cap_vld_o,
   output logic                     fault_o
);

   localparam int CODE_W = 2 * NLINE;

   if (TW < 2) begin : g_bad_timer
      $error("hall_commutator: TW must be at least 2");
   end

   logic [SW-1:0]     cand;
   logic [SW-1:0]     state;
   logic              accept;
   logic              load;
   logic [SW-1:0]     sel_state;
   logic [CODE_W-1:0] code;
   logic [TW-1:0]     cap_val_q;
   logic              cap_vld_q;

   hall_sync_filter #(.SW(SW), .SYNC_STAGES(SYNC_STAGES)) i_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_i    (hall_i),
      .cand_o   (cand),
      .state_o  (state),
      .accept_o (accept)
   );

   // sensor mode loads the state being accepted, period mode the held one
   assign load      = mc_mode_i ? period_evt_i : accept;
   assign sel_state = mc_mode_i ? state : cand;

   hall_pattern_sel #(.SW(SW), .NLINE(NLINE)) i_pattern (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .state_i   (sel_state),
      .dir_rev_i (dir_rev_i),
      .tbl_fwd_i (tbl_fwd_i),
      .tbl_rev_i (tbl_rev_i),
      .code_o    (code),
      .fault_o   (fault_o)
   );

   for (genvar g = 0; g < NLINE; g++) begin : g_line
      hall_line_drive i_drive (
         .code_i (code[2*g +: 2]),
         .pwm_i  (pwm_i),
         .line_o (phase_o[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val_q <= '0;
         cap_vld_q <= 1'b0;
      end else begin
         cap_vld_q <= accept;
         if (accept) cap_val_q <= timer_i;
      end
   end

   assign cap_val_o = cap_val_q;
   assign cap_vld_o = cap_vld_q;

   AST_INVALID_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (phase_o == '0)); // R6
   AST_CAPTURE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld_o |=> !cap_vld_o); // R4
   AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_val_o) |-> cap_vld_o); // R4
   AST_SENSOR_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(code) && !$past(mc_mode_i)) |-> cap_vld_o); // R2
   AST_PERIOD_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(code) && $past(mc_mode_i)) |-> $past(period_evt_i)); // R5

endmodule

// File: tb/test_hall_commutator.sv
module test_hall_commutator;

   localparam int  CYC = 10;
   localparam int  NV  = 9;
   // each entry: {sensor state, reverse flag}
   localparam logic [3:0] VEC [NV] = '{
      4'b1010, 4'b1000, 4'b1100, 4'b0101, 4'b0111,
      4'b1110, 4'b0010, 4'b0001, 4'b1011
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  hall_i = 3'b000;
   logic        mc_mode_i = 1'b0;
   logic        dir_rev_i = 1'b0;
   logic        period_evt_i = 1'b0;
   logic        pwm_i = 1'b0;
   logic [15:0] timer_i = 16'h0;
   logic [95:0] tbl_fwd_i;
   logic [95:0] tbl_rev_i;
   logic [5:0]  phase_o;
   logic [15:0] cap_val_o;
   logic        cap_vld_o;
   logic        fault_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CYC/2) clk = ~clk;

   hall_commutator i_hall_commutator (
      .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .mc_mode_i(mc_mode_i),
      .dir_rev_i(dir_rev_i), .period_evt_i(period_evt_i), .pwm_i(pwm_i),
      .timer_i(timer_i), .tbl_fwd_i(tbl_fwd_i), .tbl_rev_i(tbl_rev_i),
      .phase_o(phase_o), .cap_val_o(cap_val_o), .cap_vld_o(cap_vld_o),
      .fault_o(fault_o)
   );

   function automatic logic [1:0] tcode(logic rev, int st, int ln);
      return rev ? 2'((st * 3 + ln + 1) & 3) : 2'((st + ln) & 3);
   endfunction

   function automatic logic [5:0] exp_phase(logic rev, logic [2:0] st, logic pwm);
      logic [5:0] r = '0;
      if (st == 3'b000 || st == 3'b111) return '0;
      for (int ln = 0; ln < 6; ln++) begin
         case (tcode(rev, int'(st), ln))
            2'b00:   r[ln] = 1'b0;
            2'b01:   r[ln] = 1'b1;
            2'b10:   r[ln] = pwm;
            default: r[ln] = ~pwm;
         endcase
      end
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_lines(string req, logic rev, logic [2:0] st);
      for (int p = 0; p < 2; p++) begin
         pwm_i = p[0];
         #1;
         chk(req, 32'(phase_o), 32'(exp_phase(rev, st, p[0])));
      end
      pwm_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CYC * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      for (int s = 0; s < 8; s++)
         for (int ln = 0; ln < 6; ln++) begin
            tbl_fwd_i[s*12 + 2*ln +: 2] = tcode(1'b0, s, ln);
            tbl_rev_i[s*12 + 2*ln +: 2] = tcode(1'b1, s, ln);
         end

      // R8: reset state
      repeat (3) @(negedge clk);
      chk("R8 lines", 32'(phase_o), 0);
      chk("R8 fault", 32'(fault_o), 0);
      chk("R8 cap_vld", 32'(cap_vld_o), 0);
      chk("R8 cap_val", 32'(cap_val_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // vector table: R2 R3 R4 R6 in sensor mode
      for (int i = 0; i < NV; i++) begin
         hall_i    = VEC[i][3:1];
         dir_rev_i = VEC[i][0];
         timer_i   = 16'h1000 + 16'(i * 16'h0111);
         repeat (4) @(posedge clk);
         @(negedge clk);
         chk_lines("R2/R3 pattern", VEC[i][0], VEC[i][3:1]);
         chk("R4 cap_vld", 32'(cap_vld_o), 1);
         chk("R4 cap_val", 32'(cap_val_o), 32'(timer_i));
         chk("R6 fault", 32'(fault_o),
             32'(VEC[i][3:1] == 3'b000 || VEC[i][3:1] == 3'b111));
         @(negedge clk);
         chk("R4 single pulse", 32'(cap_vld_o), 0);
      end
      // accepted state now 101, reverse

      // R1: acceptance delay is exactly four edges
      hall_i  = 3'b100;
      timer_i = 16'hBEEF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 not yet accepted", 32'(cap_vld_o), 0);
      chk_lines("R1 lines held", 1'b1, 3'b101);
      @(negedge clk);
      chk("R1 accepted at fourth edge", 32'(cap_vld_o), 1);
      chk_lines("R1 new pattern", 1'b1, 3'b100);

      // R1: one-cycle glitch rejected
      hall_i = 3'b110;
      @(negedge clk);
      hall_i = 3'b100;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk("R1 glitch no capture", 32'(cap_vld_o), 0);
      end
      chk("R1 glitch cap_val held", 32'(cap_val_o), 32'hBEEF);
      chk_lines("R1 glitch lines held", 1'b1, 3'b100);

      // R7: direction change and period event ignored in sensor mode
      dir_rev_i = 1'b0;
      period_evt_i = 1'b1;
      @(negedge clk);
      period_evt_i = 1'b0;
      repeat (3) @(negedge clk);
      chk_lines("R7 lines unchanged", 1'b1, 3'b100);

      // R5: multi-channel mode
      mc_mode_i = 1'b1;
      hall_i    = 3'b110;
      timer_i   = 16'h4242;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R5 capture in period mode", 32'(cap_val_o), 32'h4242);
      chk_lines("R5 sensor edge no load", 1'b1, 3'b100);
      period_evt_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      period_evt_i = 1'b0;
      chk_lines("R5 period load fwd", 1'b0, 3'b110);
      dir_rev_i = 1'b1;
      repeat (2) @(negedge clk);
      chk_lines("R5 held without event", 1'b0, 3'b110);
      period_evt_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      period_evt_i = 1'b0;
      chk_lines("R5 period load rev", 1'b1, 3'b110);

      // R6: invalid state loaded by period event, then cleared
      hall_i = 3'b111;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R6 fault before event", 32'(fault_o), 0);
      period_evt_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      period_evt_i = 1'b0;
      chk("R6 fault set", 32'(fault_o), 1);
      chk_lines("R6 lines low", 1'b1, 3'b111);
      hall_i = 3'b011;
      repeat (4) @(posedge clk);
      @(negedge clk);
      period_evt_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      period_evt_i = 1'b0;
      chk("R6 fault cleared", 32'(fault_o), 0);
      chk_lines("R6 valid again", 1'b1, 3'b011);

      finish_run();
   end

endmodule